// File: doc/BRIEF.md
# MSI to Adapter Interrupt Indicator Unit

This unit sits behind the message-signalled interrupt window of one PCI function. Each write into the window carries a function index in its upper bits and a vector number in its low bits. When the function is attached and enabled, the unit sets one indicator bit for that vector in memory. It then sets the function's summary bit. It raises an adapter interrupt tagged with the function's interrupt subclass only when the summary byte read back as zero, meaning nobody has yet been told about pending work.

Memory is reached through a byte-wide atomic-OR port that handles one request at a time. Each request names a byte address and a set mask. The memory ORs the mask into the byte and returns the old byte value, or reports that the address could not be mapped. Bits are numbered most-significant first inside each byte.

The unit reports two failures as error event records. A write arriving for a function that is not attached produces one kind. A memory access that cannot be mapped produces the other. Reads of the window always return all ones.

Top module: `msi_ind_unit`

## Requirements
- R1: Write data bits [4:0] are the vector number. The bits above them, [DW-1:5], are the function index.
- R2: A write with `fn_present` low makes no memory access and raises no interrupt. One cycle later it produces an error record with kind 1 (no-MSI). The record's handle is the function index, its fault address is `wr_addr`, and its word is the vector shifted left by ERR_SHIFT (default 8).
- R3: A write to an attached function whose `fn_state` is not 2'b11 (enabled) is dropped. It makes no memory access, no error record and no interrupt.
- R4: Indicator bit number n = `ind_off` + vector, computed without truncation. The unit ORs mask 8'h80 >> (n mod 8) into the byte at `ind_base` + n/8.
- R5: The summary access ORs mask 8'h80 >> (`sum_off` mod 8) into the byte at `sum_base` + `sum_off`/8. It is issued only after the indicator access has been acknowledged.
- R6: `irq_pulse` is high for exactly one cycle, carrying `irq_isc` = `isc`, when the summary access succeeds and its old byte was 8'h00. The test is on the whole byte, not the single bit. Otherwise no interrupt is raised.
- R7: A memory access acknowledged with `mem_fail` produces an error record one cycle later. The record has kind 2 (routing error) and a zero handle, address and word. A failed indicator access still proceeds to the summary access. A failed summary access raises no interrupt.
- R8: A cycle with `rd_valid` high is answered in the next cycle by `rd_rvalid` high with `rd_data` all ones.
- R9: Only one memory request is outstanding at a time. `mem_req`, `mem_addr` and `mem_mask` hold until `mem_ack`. `wr_ready` is low from the cycle after a write is accepted until its last access completes.
- R10: After reset, `wr_ready` is high and `mem_req`, `irq_pulse`, `err_valid` and `rd_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write into the MSI window |
| wr_ready | output | 1 | Unit can accept a write |
| wr_addr | input | AW | Window address of the write |
| wr_data | input | DW | Write data: index and vector |
| rd_valid | input | 1 | Read of the MSI window |
| rd_rvalid | output | 1 | Read data valid |
| rd_data | output | DW | Read data (all ones) |
| fn_present | input | 1 | A function is attached |
| fn_state | input | 2 | Function state, 2'b11 = enabled |
| ind_base | input | MAW | Indicator area byte address |
| ind_off | input | OW | Indicator bit offset |
| sum_base | input | MAW | Summary area byte address |
| sum_off | input | OW | Summary bit offset |
| isc | input | IW | Interrupt subclass |
| mem_req | output | 1 | Atomic-OR request |
| mem_addr | output | MAW | Byte address |
| mem_mask | output | 8 | Bits to OR in |
| mem_ack | input | 1 | Request done (one-cycle pulse) |
| mem_fail | input | 1 | Address not mappable, valid with ack |
| mem_old | input | 8 | Byte value before the OR, valid with ack |
| irq_pulse | output | 1 | Adapter interrupt |
| irq_isc | output | IW | Subclass of the interrupt |
| err_valid | output | 1 | Error record valid |
| err_kind | output | 2 | 1 = no-MSI, 2 = routing error |
| err_handle | output | DW-5 | Function index of the record |
| err_faddr | output | AW | Fault address of the record |
| err_word | output | ERR_W | Error word of the record |

## Verification
Writes are driven with the indicator offset at zero and at values that move the bit across byte boundaries. One case carries the bit number past the offset width, which separates a truncating adder from a correct one. Summary bytes are left clear, left holding the same bit, and left holding only a different bit. This distinguishes a whole-byte zero test from a single-bit test, and shows that a cleared summary re-arms the interrupt. Absent and non-enabled functions show the no-MSI record and the silent drop apart. Failures injected on each of the two accesses separate "continue to summary" from "suppress interrupt". A slow memory exposes request ordering and the busy window.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_IND  = 2'd1,
    SQ_SUM  = 2'd2
  } sq_state_t;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_NO_MSI = 2'd1,
    EV_ROUTE  = 2'd2
  } ev_kind_t;

  localparam logic [1:0] FN_ST_ENABLED = 2'b11;
  localparam int         BYTE_W        = 8;

  // Bit 0 of a byte-level bit number is the most significant bit
  function automatic logic [BYTE_W-1:0] msb_first_mask(input logic [2:0] pos);
    return 8'h80 >> pos;
  endfunction

endpackage

// File: rtl/msi_bit_locate.sv
module msi_bit_locate #(
  parameter int MAW = 32,
  parameter int OW  = 16,
  parameter int VW  = 5
) (
  input  logic [MAW-1:0] base,
  input  logic [OW-1:0]  off,
  input  logic [VW-1:0]  add,
  output logic [MAW-1:0] byte_addr,
  output logic [7:0]     mask
);
  import msi_ind_pkg::*;

  localparam int NW = OW + 1;

  logic [NW-1:0] bitno;

  // One extra bit so offset + vector never wraps
  assign bitno     = NW'(off) + NW'(add);
  assign byte_addr = base + MAW'(bitno[NW-1:3]);
  assign mask      = msb_first_mask(bitno[2:0]);

endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq #(
  parameter int MAW = 32,
  parameter int IW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [MAW-1:0] ind_addr,
  input  logic [7:0]     ind_mask,
  input  logic [MAW-1:0] sum_addr,
  input  logic [7:0]     sum_mask,
  input  logic [IW-1:0]  isc,
  output logic           mem_req,
  output logic [MAW-1:0] mem_addr,
  output logic [7:0]     mem_mask,
  input  logic           mem_ack,
  input  logic           mem_fail,
  input  logic [7:0]     mem_old,
  output logic           busy,
  output logic           route_fail,
  output logic           irq_pulse,
  output logic [IW-1:0]  irq_isc
);
  import msi_ind_pkg::*;

  sq_state_t      st;
  logic [MAW-1:0] sum_addr_q;
  logic [7:0]     sum_mask_q;
  logic [IW-1:0]  isc_q;

  assign busy       = (st != SQ_IDLE);
  assign route_fail = busy && mem_ack && mem_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      mem_mask   <= '0;
      sum_addr_q <= '0;
      sum_mask_q <= '0;
      isc_q      <= '0;
      irq_pulse  <= 1'b0;
      irq_isc    <= '0;
    end else begin
      irq_pulse <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            mem_req    <= 1'b1;
            mem_addr   <= ind_addr;
            mem_mask   <= ind_mask;
            sum_addr_q <= sum_addr;
            sum_mask_q <= sum_mask;
            isc_q      <= isc;
            st         <= SQ_IND;
          end
        end
        SQ_IND: begin
          // Indicator done (or failed): summary follows regardless
          if (mem_ack) begin
            mem_addr <= sum_addr_q;
            mem_mask <= sum_mask_q;
            st       <= SQ_SUM;
          end
        end
        SQ_SUM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            irq_pulse <= !mem_fail && (mem_old == 8'h00);
            irq_isc   <= isc_q;
            st        <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msi_err_rec.sv
module msi_err_rec #(
  parameter int IDXW  = 27,
  parameter int VW    = 5,
  parameter int AW    = 32,
  parameter int EW    = 32,
  parameter int SHIFT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nomsi,
  input  logic [IDXW-1:0] idx,
  input  logic [VW-1:0]   vec,
  input  logic [AW-1:0]   waddr,
  input  logic            route_fail,
  output logic            err_valid,
  output logic [1:0]      err_kind,
  output logic [IDXW-1:0] err_handle,
  output logic [AW-1:0]   err_faddr,
  output logic [EW-1:0]   err_word
);
  import msi_ind_pkg::*;

  // nomsi only fires while idle, route_fail only while busy: never together
  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid  <= 1'b0;
      err_kind   <= EV_NONE;
      err_handle <= '0;
      err_faddr  <= '0;
      err_word   <= '0;
    end else if (nomsi) begin
      err_valid  <= 1'b1;
      err_kind   <= EV_NO_MSI;
      err_handle <= idx;
      err_faddr  <= waddr;
      err_word   <= EW'(vec) << SHIFT;
    end else if (route_fail) begin
      err_valid  <= 1'b1;
      err_kind   <= EV_ROUTE;
      err_handle <= '0;
      err_faddr  <= '0;
      err_word   <= '0;
    end else begin
      err_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/msi_rd_resp.sv
module msi_rd_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  output logic          rd_rvalid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_rvalid <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_rvalid <= rd_valid;
      if (rd_valid) rd_data <= '1;
    end
  end

endmodule

// File: rtl/msi_ind_unit.sv
module msi_ind_unit #(
  parameter int DW        = 32,
  parameter int VW        = 5,
  parameter int AW        = 32,
  parameter int MAW       = 32,
  parameter int OW        = 16,
  parameter int IW        = 3,
  parameter int ERR_W     = 32,
  parameter int ERR_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_valid,
  output logic               rd_rvalid,
  output logic [DW-1:0]      rd_data,
  input  logic               fn_present,
  input  logic [1:0]         fn_state,
  input  logic [MAW-1:0]     ind_base,
  input  logic [OW-1:0]      ind_off,
  input  logic [MAW-1:0]     sum_base,
  input  logic [OW-1:0]      sum_off,
  input  logic [IW-1:0]      isc,
  output logic               mem_req,
  output logic [MAW-1:0]     mem_addr,
  output logic [7:0]         mem_mask,
  input  logic               mem_ack,
  input  logic               mem_fail,
  input  logic [7:0]         mem_old,
  output logic               irq_pulse,
  output logic [IW-1:0]      irq_isc,
  output logic               err_valid,
  output logic [1:0]         err_kind,
  output logic [DW-VW-1:0]   err_handle,
  output logic [AW-1:0]      err_faddr,
  output logic [ERR_W-1:0]   err_word
);
  import msi_ind_pkg::*;

  localparam int IDXW = DW - VW;

  logic [IDXW-1:0] w_idx;
  logic [VW-1:0]   w_vec;
  logic            busy;
  logic            accept;
  logic            nomsi;
  logic            start;
  logic            route_fail;
  logic [MAW-1:0]  ind_addr_c;
  logic [7:0]      ind_mask_c;
  logic [MAW-1:0]  sum_addr_c;
  logic [7:0]      sum_mask_c;

  assign w_idx    = wr_data[DW-1:VW];
  assign w_vec    = wr_data[VW-1:0];
  assign wr_ready = !busy;
  assign accept   = wr_valid && !busy;
  assign nomsi    = accept && !fn_present;
  assign start    = accept && fn_present && (fn_state == FN_ST_ENABLED);

  msi_bit_locate #(.MAW(MAW), .OW(OW), .VW(VW)) u_loc_ind (
    .base(ind_base), .off(ind_off), .add(w_vec),
    .byte_addr(ind_addr_c), .mask(ind_mask_c)
  );

  msi_bit_locate #(.MAW(MAW), .OW(OW), .VW(VW)) u_loc_sum (
    .base(sum_base), .off(sum_off), .add('0),
    .byte_addr(sum_addr_c), .mask(sum_mask_c)
  );

  msi_rmw_seq #(.MAW(MAW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .ind_addr(ind_addr_c), .ind_mask(ind_mask_c),
    .sum_addr(sum_addr_c), .sum_mask(sum_mask_c), .isc(isc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_mask(mem_mask),
    .mem_ack(mem_ack), .mem_fail(mem_fail), .mem_old(mem_old),
    .busy(busy), .route_fail(route_fail),
    .irq_pulse(irq_pulse), .irq_isc(irq_isc)
  );

  msi_err_rec #(.IDXW(IDXW), .VW(VW), .AW(AW), .EW(ERR_W), .SHIFT(ERR_SHIFT)) u_err (
    .clk(clk), .rst(rst), .nomsi(nomsi), .idx(w_idx), .vec(w_vec),
    .waddr(wr_addr), .route_fail(route_fail),
    .err_valid(err_valid), .err_kind(err_kind), .err_handle(err_handle),
    .err_faddr(err_faddr), .err_word(err_word)
  );

  msi_rd_resp #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_valid(rd_valid),
    .rd_rvalid(rd_rvalid), .rd_data(rd_data)
  );

endmodule

// File: rtl/msi_ind_chk.sv
module msi_ind_chk #(
  parameter int DW  = 32,
  parameter int MAW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_ready,
  input logic           rd_valid,
  input logic           rd_rvalid,
  input logic [DW-1:0]  rd_data,
  input logic           mem_req,
  input logic [MAW-1:0] mem_addr,
  input logic [7:0]     mem_mask,
  input logic           mem_ack,
  input logic           mem_fail,
  input logic [7:0]     mem_old,
  input logic           irq_pulse,
  input logic           err_valid,
  input logic [1:0]     err_kind
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_mask)); // R9

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !wr_ready); // R9

  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $countones(mem_mask) == 1); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(mem_ack && !mem_fail && mem_old == 8'h00)); // R6

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse); // R6

  AST_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_rvalid && (rd_data == '1)); // R8

  AST_NOMSI_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    err_valid && err_kind == 2'd1 |-> !mem_req); // R2

  AST_ROUTE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_valid && err_kind == 2'd2 |-> $past(mem_ack && mem_fail)); // R7

endmodule

bind msi_ind_unit msi_ind_chk #(.DW(DW), .MAW(MAW)) u_chk (
  .clk(clk), .rst(rst), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_rvalid(rd_rvalid), .rd_data(rd_data), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_ack(mem_ack),
  .mem_fail(mem_fail), .mem_old(mem_old), .irq_pulse(irq_pulse),
  .err_valid(err_valid), .err_kind(err_kind)
);

// File: tb/sim_msi_ind_unit.sv
`timescale 1ns/1ps
module sim_msi_ind_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_rvalid;
  logic [31:0] rd_data;
  logic        fn_present = 1'b1;
  logic [1:0]  fn_state = 2'b11;
  logic [31:0] ind_base = 32'h40;
  logic [15:0] ind_off = '0;
  logic [31:0] sum_base = 32'h80;
  logic [15:0] sum_off = '0;
  logic [2:0]  isc = 3'd5;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [7:0]  mem_mask;
  logic        mem_ack = 1'b0;
  logic        mem_fail = 1'b0;
  logic [7:0]  mem_old = '0;
  logic        irq_pulse;
  logic [2:0]  irq_isc;
  logic        err_valid;
  logic [1:0]  err_kind;
  logic [26:0] err_handle;
  logic [31:0] err_faddr;
  logic [31:0] err_word;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem_b [256];
  logic [31:0] acc_addr [8];
  int acc_cnt = 0, irq_cnt = 0, err_cnt = 0, lat = 0;
  logic [2:0]  last_isc;
  logic [1:0]  last_kind;
  logic [26:0] last_handle;
  logic [31:0] last_faddr, last_word;
  logic        fail_en = 1'b0;
  logic [31:0] fail_addr = '0;
  logic        busy_seen;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  msi_ind_unit u0 (.*);

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Memory: atomic OR, one-cycle ack after lat idle cycles
  initial begin
    bit given = 0;
    int wc = 0;
    for (int i = 0; i < 256; i++) mem_b[i] = '0;
    forever begin
      @(negedge clk);
      if (given) begin
        mem_ack = 1'b0; given = 0;
      end else if (mem_req) begin
        if (wc < lat) wc++;
        else begin
          wc = 0; mem_ack = 1'b1; given = 1;
          if (acc_cnt < 8) acc_addr[acc_cnt] = mem_addr;
          acc_cnt++;
          if (fail_en && mem_addr == fail_addr) begin
            mem_fail = 1'b1; mem_old = 8'h00;
          end else begin
            mem_fail = 1'b0; mem_old = mem_b[mem_addr[7:0]];
            mem_b[mem_addr[7:0]] = mem_b[mem_addr[7:0]] | mem_mask;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq_pulse) begin irq_cnt++; last_isc = irq_isc; end
      if (err_valid) begin
        err_cnt++; last_kind = err_kind; last_handle = err_handle;
        last_faddr = err_faddr; last_word = err_word;
      end
    end
  end

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem_b[i] = '0;
    acc_cnt = 0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [26:0] ix, input logic [4:0] v);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = {ix, v};
    @(negedge clk);
    wr_valid = 1'b0;
    busy_seen = !wr_ready;
    for (int k = 0; k < 80 && !wr_ready; k++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 wr_ready", wr_ready, 1);
    check("R10 mem_req", mem_req, 0);
    check("R10 irq_pulse", irq_pulse, 0);
    check("R10 err_valid", err_valid, 0);
    check("R10 rd_rvalid", rd_rvalid, 0);
  endtask

  task automatic t_basic();
    int i0 = irq_cnt;
    clr_mem(); ind_off = 0; sum_off = 0; isc = 3'd5;
    do_write(32'h10, 27'd7, 5'd3);
    check("R1 R4 indicator byte", mem_b[8'h40], 8'h10);
    check("R5 summary byte", mem_b[8'h80], 8'h80);
    check("R6 irq raised", irq_cnt - i0, 1);
    check("R6 irq subclass", last_isc, 3'd5);
    check("R5 access count", acc_cnt, 2);
  endtask

  task automatic t_offsets();
    int i0 = irq_cnt;
    clr_mem(); ind_off = 16'd13; sum_off = 16'd10; isc = 3'd2;
    do_write(32'h10, 27'd1, 5'd6);
    check("R4 offset indicator byte", mem_b[8'h42], 8'h10);
    check("R5 offset summary byte", mem_b[8'h81], 8'h20);
    check("R5 indicator first", acc_addr[0], 32'h42);
    check("R5 summary second", acc_addr[1], 32'h81);
    check("R6 irq offset", irq_cnt - i0, 1);
    check("R6 isc offset", last_isc, 3'd2);
  endtask

  task automatic t_summary_busy();
    int i0 = irq_cnt;
    do_write(32'h10, 27'd1, 5'd7);
    check("R4 OR keeps bits", mem_b[8'h42], 8'h18);
    check("R6 same bit no irq", irq_cnt - i0, 0);
    sum_off = 16'd8;
    do_write(32'h10, 27'd1, 5'd7);
    check("R6 other bit set no irq", irq_cnt - i0, 0);
    check("R5 summary other bit", mem_b[8'h81], 8'hA0);
    mem_b[8'h81] = 8'h00;
    do_write(32'h10, 27'd1, 5'd7);
    check("R6 rearm irq", irq_cnt - i0, 1);
  endtask

  task automatic t_nomsi();
    int i0 = irq_cnt, e0 = err_cnt;
    clr_mem(); fn_present = 1'b0;
    do_write(32'h1234, 27'h155, 5'h11);
    check("R2 one record", err_cnt - e0, 1);
    check("R2 kind", last_kind, 2'd1);
    check("R2 handle", last_handle, 27'h155);
    check("R2 faddr", last_faddr, 32'h1234);
    check("R2 word", last_word, 32'h1100);
    check("R2 no access", acc_cnt, 0);
    check("R2 no irq", irq_cnt - i0, 0);
    fn_present = 1'b1;
  endtask

  task automatic t_disabled();
    int i0 = irq_cnt, e0 = err_cnt;
    clr_mem(); fn_state = 2'b10;
    do_write(32'h10, 27'd3, 5'd1);
    check("R3 no access", acc_cnt, 0);
    check("R3 no record", err_cnt - e0, 0);
    check("R3 no irq", irq_cnt - i0, 0);
    check("R3 memory untouched", mem_b[8'h40], 8'h00);
    fn_state = 2'b11;
  endtask

  task automatic t_ind_fail();
    int i0 = irq_cnt, e0 = err_cnt;
    clr_mem(); ind_off = 0; sum_off = 0;
    fail_en = 1'b1; fail_addr = 32'h40;
    do_write(32'h10, 27'd2, 5'd0);
    check("R7 ind fail record", err_cnt - e0, 1);
    check("R7 ind fail kind", last_kind, 2'd2);
    check("R7 ind fail fields", {last_handle, last_faddr, last_word}, 0);
    check("R7 summary still set", mem_b[8'h80], 8'h80);
    check("R7 irq after ind fail", irq_cnt - i0, 1);
    fail_en = 1'b0;
  endtask

  task automatic t_sum_fail();
    int i0 = irq_cnt, e0 = err_cnt;
    clr_mem(); ind_off = 0; sum_off = 0;
    fail_en = 1'b1; fail_addr = 32'h80;
    do_write(32'h10, 27'd2, 5'd9);
    check("R7 sum fail record", err_cnt - e0, 1);
    check("R7 sum fail kind", last_kind, 2'd2);
    check("R7 sum fail no irq", irq_cnt - i0, 0);
    check("R7 indicator set", mem_b[8'h41], 8'h40);
    fail_en = 1'b0;
  endtask

  task automatic t_read();
    @(negedge clk); rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    check("R8 rvalid", rd_rvalid, 1);
    check("R8 data ones", rd_data, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 rvalid drops", rd_rvalid, 0);
  endtask

  task automatic t_slow_wide();
    clr_mem(); lat = 3; ind_off = 16'hFFF0; sum_off = 16'd3;
    do_write(32'h10, 27'd4, 5'd31);
    check("R9 busy after accept", busy_seen, 1);
    check("R4 carry address", acc_addr[0], 32'h2041);
    check("R4 carry mask", mem_b[8'h41], 8'h01);
    check("R5 slow summary", mem_b[8'h80], 8'h10);
    check("R9 two accesses", acc_cnt, 2);
    check("R9 ready again", wr_ready, 1);
    lat = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_basic();
    t_offsets();
    t_summary_busy();
    t_nomsi();
    t_disabled();
    t_ind_fail();
    t_sum_fail();
    t_read();
    t_slow_wide();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule